// File: doc/BRIEF.md
# Three-Target Chip-Select Sequencer

This block lets one synchronous serial word engine serve three peripherals: a touch controller (target 0), a monitor ADC (target 1) and a backlight DAC (target 2). Each target has its own active-low select line and its own frame configuration word. The sequencer keeps the lines of the unused targets high. Before it selects a target it clears the frame configuration register to zero, and only then loads that target's word.

A client issues single-cycle requests with a 2-bit operation and a 2-bit target ID. The operation codes are: 01 start, 10 stop, 11 exchange, and 00 does nothing. A start opens a session that leaves the target selected. For the touch target, start also pushes one word after a setup wait. The session is closed by a stop, which deselects every target and returns the touch target's reply; the other targets return zero. An exchange does the whole select, send, receive and deselect sequence in one request. The shifter inside the block is a plain word engine with transmit-not-full and receive-not-empty flags.

Top module: `csel_seq`

## Requirements
- R1: After reset all three select lines are high, and busy, done, err, sclk, mosi, cfg_q and rsp_data are all zero.
- R2: At no time is more than one select line low. While busy is high, exactly one line is low: bit n of cs_n for target ID n (0 touch, 1 monitor, 2 backlight).
- R3: Whenever cfg_q moves away from a nonzero value, it moves to zero. After a valid start, cfg_q holds the target's word: 16'h06AB for touch, 16'h0387 for monitor, 16'h01AB for backlight.
- R4: The engine sends cfg_q[3:0]+1 bits, MSB first, on mosi and samples miso on each rising sclk edge. sclk idles low, and each sclk half period lasts cfg_q[15:8]+1 clock cycles. The touch word is therefore 12 bits, with each half period 7 cycles.
- R5: A start on the touch target lowers the select line and waits at least SETUP_CYC (13) cycles before the first rising sclk edge. It sends req_data, and busy rises once the engine has taken the word. A start on the monitor or backlight target raises busy and produces no sclk edge.
- R6: A stop in a touch session waits for the reply word and returns it on rsp_data. A stop in a monitor or backlight session returns zero. A stop while idle returns zero. A stop ignores req_tgt.
- R7: Each done pulse coincides with all select lines high and busy low. busy falls only together with done.
- R8: An exchange selects the target, waits SETUP_CYC cycles, sends one word and deselects the target. It returns the received word for touch and monitor, and zero for backlight. busy stays low throughout.
- R9: A start or exchange with target ID 3 raises err and done for one cycle, returns zero, and leaves every select line high and busy low.
- R10: A start or exchange while busy has no effect, and neither does any request that arrives while a sequence is running. No done or err pulse appears, and cs_n, busy and cfg_q keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_op | input | 2 | 01 start, 10 stop, 11 exchange |
| req_tgt | input | 2 | Target ID, 0..2 valid |
| req_data | input | WORD_W | Word to send |
| miso | input | 1 | Serial data from the selected target |
| busy | output | 1 | Session open (start done, stop pending) |
| done | output | 1 | Stop, exchange or rejected request finished |
| err | output | 1 | Invalid target ID pulse |
| rsp_data | output | WORD_W | Returned word, valid with done |
| cs_n | output | 3 | Active-low selects, bit n for target n |
| cfg_q | output | CFG_W | Current frame configuration |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the selected target |

## Verification
A new request can meet a sequence that is still running. The hazard is a stop that arrives while an exchange is still shifting its word, or a second start while a session is open. The bench provokes the first case by issuing a stop a few cycles after an exchange, and the second by issuing start and exchange during an open monitor session. It judges both by counting done pulses: there must be exactly one for the exchange and none for the ignored requests. It also confirms that rsp_data, cs_n, busy and cfg_q still match the sequence that owns the engine.

// File: rtl/csel_pkg.sv
`timescale 1ns/1ps
package csel_pkg;
  localparam int N_TGT = 3;
  localparam logic [1:0] TGT_TOUCH = 2'd0;
  localparam logic [1:0] TGT_MON   = 2'd1;
  localparam logic [1:0] TGT_BL    = 2'd2;

  // frame configuration fields
  localparam int SIZE_LSB = 0;
  localparam int SIZE_W   = 4;
  localparam int DIV_LSB  = 8;
  localparam int DIV_W    = 8;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_START = 2'd1,
    OP_STOP  = 2'd2,
    OP_XCHG  = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_CLR, ST_LOAD, ST_SETUP, ST_PUSH,
    ST_TXW, ST_HELD, ST_RXW, ST_CLOSE
  } seq_st_e;
endpackage

// File: rtl/csel_rst_sync.sv
`timescale 1ns/1ps
module csel_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/csel_cfg_bank.sv
`timescale 1ns/1ps
module csel_cfg_bank
  import csel_pkg::*;
#(
  parameter int          CFG_W     = 16,
  parameter logic [15:0] CFG_TOUCH = 16'h06AB,
  parameter logic [15:0] CFG_MON   = 16'h0387,
  parameter logic [15:0] CFG_BL    = 16'h01AB
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [1:0]       tgt,
  output logic [CFG_W-1:0] cfg_q
);
  logic [CFG_W-1:0] sel_word;
  logic [CFG_W-1:0] cfg_n;
  logic             cfg_en;

  always_comb begin
    unique case (tgt)
      TGT_TOUCH: sel_word = CFG_W'(CFG_TOUCH);
      TGT_MON:   sel_word = CFG_W'(CFG_MON);
      default:   sel_word = CFG_W'(CFG_BL);
    endcase
  end

  assign cfg_en = clr | load;
  assign cfg_n  = clr ? '0 : sel_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_en) cfg_q <= cfg_n;
  end

  // R3: a live configuration is only ever replaced by zero
  assert_cfg_clear_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(cfg_q) != '0) && (cfg_q != $past(cfg_q))) |-> (cfg_q == '0));
endmodule

// File: rtl/csel_cs_drv.sv
`timescale 1ns/1ps
module csel_cs_drv
  import csel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rel_all,
  input  logic             sel_en,
  input  logic [1:0]       tgt,
  output logic [N_TGT-1:0] cs_n
);
  for (genvar g = 0; g < N_TGT; g++) begin : g_line
    logic line_en;
    logic line_n;
    assign line_en = rel_all | (sel_en && (tgt == 2'(g)));
    assign line_n  = rel_all;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cs_n[g] <= 1'b1;
      else if (line_en) cs_n[g] <= line_n;
    end
  end

  // R2: never two targets selected together
  assert_one_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~cs_n) <= 1);
endmodule

// File: rtl/csel_word_engine.sv
`timescale 1ns/1ps
module csel_word_engine
  import csel_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SIZE_W-1:0] last_idx,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              push,
  input  logic [WORD_W-1:0] push_data,
  input  logic              pop,
  input  logic              miso,
  output logic              tx_nf,
  output logic              rx_ne,
  output logic [WORD_W-1:0] rx_data,
  output logic              sclk,
  output logic              mosi
);
  logic              tx_full_q, tx_full_n;
  logic [WORD_W-1:0] tx_word_q, tx_word_n;
  logic              active_q, active_n;
  logic [WORD_W-1:0] sh_q, sh_n;
  logic [WORD_W-1:0] rs_q, rs_n;
  logic [SIZE_W-1:0] bit_q, bit_n;
  logic [DIV_W-1:0]  div_q, div_n;
  logic              sclk_q, sclk_n;
  logic              rxv_q, rxv_n;
  logic [WORD_W-1:0] rxw_q, rxw_n;
  logic              tick;

  assign tick = (div_q == half_div);

  always_comb begin
    tx_full_n = tx_full_q;
    tx_word_n = tx_word_q;
    active_n  = active_q;
    sh_n      = sh_q;
    rs_n      = rs_q;
    bit_n     = bit_q;
    div_n     = div_q;
    sclk_n    = sclk_q;
    rxv_n     = rxv_q;
    rxw_n     = rxw_q;
    if (pop) rxv_n = 1'b0;
    if (!active_q) begin
      if (tx_full_q) begin
        active_n  = 1'b1;
        sh_n      = tx_word_q;
        rs_n      = '0;
        bit_n     = '0;
        div_n     = '0;
        sclk_n    = 1'b0;
        tx_full_n = 1'b0;
      end
    end else begin
      div_n = tick ? '0 : div_q + 1'b1;
      if (tick) begin
        if (!sclk_q) begin
          sclk_n = 1'b1;
          rs_n   = {rs_q[WORD_W-2:0], miso};
        end else begin
          sclk_n = 1'b0;
          sh_n   = sh_q << 1;
          if (bit_q == last_idx) begin
            active_n = 1'b0;
            rxv_n    = 1'b1;
            rxw_n    = rs_q;
          end else begin
            bit_n = bit_q + 1'b1;
          end
        end
      end
    end
    if (push) begin
      tx_full_n = 1'b1;
      tx_word_n = push_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full_q <= 1'b0;
      tx_word_q <= '0;
      active_q  <= 1'b0;
      sh_q      <= '0;
      rs_q      <= '0;
      bit_q     <= '0;
      div_q     <= '0;
      sclk_q    <= 1'b0;
      rxv_q     <= 1'b0;
      rxw_q     <= '0;
    end else begin
      tx_full_q <= tx_full_n;
      tx_word_q <= tx_word_n;
      active_q  <= active_n;
      sh_q      <= sh_n;
      rs_q      <= rs_n;
      bit_q     <= bit_n;
      div_q     <= div_n;
      sclk_q    <= sclk_n;
      rxv_q     <= rxv_n;
      rxw_q     <= rxw_n;
    end
  end

  assign tx_nf   = ~tx_full_q;
  assign rx_ne   = rxv_q;
  assign rx_data = rxw_q;
  assign sclk    = sclk_q;
  assign mosi    = active_q & sh_q[last_idx];

  // R5: the sequencer only pushes into an empty holding slot
  assert_push_room_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> tx_full_q == 1'b0);
  // R6: the sequencer only takes a reply that has arrived
  assert_pop_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> rxv_q);
  // R4: the serial clock rests low between frames
  assert_sclk_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !$past(active_q)) |-> !sclk_q);
endmodule

// File: rtl/csel_seq.sv
`timescale 1ns/1ps
module csel_seq
  import csel_pkg::*;
#(
  parameter int          WORD_W    = 16,
  parameter int          CFG_W     = 16,
  parameter int          SETUP_CYC = 13,
  parameter logic [15:0] CFG_TOUCH = 16'h06AB,
  parameter logic [15:0] CFG_MON   = 16'h0387,
  parameter logic [15:0] CFG_BL    = 16'h01AB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [1:0]        req_tgt,
  input  logic [WORD_W-1:0] req_data,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] rsp_data,
  output logic [2:0]        cs_n,
  output logic [CFG_W-1:0]  cfg_q,
  output logic              sclk,
  output logic              mosi
);
  localparam int         CNT_W     = $clog2(SETUP_CYC + 1);
  localparam logic [1:0] TGT_LIMIT = 2'(N_TGT);

  logic rst_sync_n;
  op_e  op_w;

  seq_st_e           st_q, st_n;
  logic [1:0]        tgt_q, tgt_n;
  logic [WORD_W-1:0] data_q, data_n;
  logic              xchg_q, xchg_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              busy_q, busy_n;
  logic              done_q, done_n;
  logic              err_q, err_n;
  logic [WORD_W-1:0] rsp_q, rsp_n;

  logic cfg_clr, cfg_load, cs_rel, cs_set, eng_push, eng_pop;
  logic tx_nf, rx_ne;
  logic [WORD_W-1:0] rx_data;

  assign op_w = op_e'(req_op);

  csel_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  csel_cfg_bank #(
    .CFG_W(CFG_W), .CFG_TOUCH(CFG_TOUCH), .CFG_MON(CFG_MON), .CFG_BL(CFG_BL)
  ) u_cfg (
    .clk(clk), .rst_n(rst_sync_n), .clr(cfg_clr), .load(cfg_load),
    .tgt(tgt_q), .cfg_q(cfg_q)
  );

  csel_cs_drv u_cs (
    .clk(clk), .rst_n(rst_sync_n), .rel_all(cs_rel), .sel_en(cs_set),
    .tgt(tgt_q), .cs_n(cs_n)
  );

  csel_word_engine #(.WORD_W(WORD_W)) u_eng (
    .clk(clk), .rst_n(rst_sync_n),
    .last_idx(cfg_q[SIZE_LSB +: SIZE_W]), .half_div(cfg_q[DIV_LSB +: DIV_W]),
    .push(eng_push), .push_data(data_q), .pop(eng_pop), .miso(miso),
    .tx_nf(tx_nf), .rx_ne(rx_ne), .rx_data(rx_data), .sclk(sclk), .mosi(mosi)
  );

  always_comb begin
    st_n     = st_q;
    tgt_n    = tgt_q;
    data_n   = data_q;
    xchg_n   = xchg_q;
    cnt_n    = cnt_q;
    busy_n   = busy_q;
    done_n   = 1'b0;
    err_n    = 1'b0;
    rsp_n    = rsp_q;
    cfg_clr  = 1'b0;
    cfg_load = 1'b0;
    cs_rel   = 1'b0;
    cs_set   = 1'b0;
    eng_push = 1'b0;
    eng_pop  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (op_w == OP_STOP) begin
            done_n = 1'b1;
            rsp_n  = '0;
            cs_rel = 1'b1;
          end else if (op_w == OP_START || op_w == OP_XCHG) begin
            if (req_tgt < TGT_LIMIT) begin
              tgt_n  = req_tgt;
              data_n = req_data;
              xchg_n = (op_w == OP_XCHG);
              st_n   = ST_CLR;
            end else begin
              err_n  = 1'b1;
              done_n = 1'b1;
              rsp_n  = '0;
              cs_rel = 1'b1;
            end
          end
        end
      end
      ST_CLR: begin
        cfg_clr = 1'b1;
        cs_rel  = 1'b1;
        st_n    = ST_LOAD;
      end
      ST_LOAD: begin
        cfg_load = 1'b1;
        cs_set   = 1'b1;
        cnt_n    = '0;
        if (xchg_q || tgt_q == TGT_TOUCH) begin
          st_n = ST_SETUP;
        end else begin
          st_n   = ST_HELD;
          busy_n = 1'b1;
        end
      end
      ST_SETUP: begin
        cnt_n = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(SETUP_CYC - 1)) st_n = ST_PUSH;
      end
      ST_PUSH: begin
        if (tx_nf) begin
          eng_push = 1'b1;
          st_n     = ST_TXW;
        end
      end
      ST_TXW: begin
        if (tx_nf) begin
          if (xchg_q) begin
            st_n = ST_RXW;
          end else begin
            st_n   = ST_HELD;
            busy_n = 1'b1;
          end
        end
      end
      ST_HELD: begin
        if (req_valid && op_w == OP_STOP) begin
          if (tgt_q == TGT_TOUCH) begin
            st_n = ST_RXW;
          end else begin
            rsp_n = '0;
            st_n  = ST_CLOSE;
          end
        end
      end
      ST_RXW: begin
        if (rx_ne) begin
          eng_pop = 1'b1;
          rsp_n   = (xchg_q && tgt_q == TGT_BL) ? '0 : rx_data;
          st_n    = ST_CLOSE;
        end
      end
      ST_CLOSE: begin
        cs_rel = 1'b1;
        done_n = 1'b1;
        busy_n = 1'b0;
        st_n   = ST_IDLE;
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q   <= ST_IDLE;
      tgt_q  <= TGT_TOUCH;
      data_q <= '0;
      xchg_q <= 1'b0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      rsp_q  <= '0;
    end else begin
      st_q   <= st_n;
      tgt_q  <= tgt_n;
      data_q <= data_n;
      xchg_q <= xchg_n;
      cnt_q  <= cnt_n;
      busy_q <= busy_n;
      done_q <= done_n;
      err_q  <= err_n;
      rsp_q  <= rsp_n;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign err      = err_q;
  assign rsp_data = rsp_q;

  // R7: completion always leaves every target released and no session
  assert_done_release_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done_q |-> ((&cs_n) && !busy_q));
  // R7: a session only ends with a completion pulse
  assert_busy_fall_done_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy_q) |-> done_q);
  // R2: an open session owns exactly one select line
  assert_busy_one_cs_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_q |-> ($countones(~cs_n) == 1));
  // R9: a rejected request reports zero with its completion
  assert_err_zero_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    err_q |-> (done_q && rsp_q == '0 && (&cs_n)));
endmodule

// File: tb/csel_seq_test.sv
`timescale 1ns/1ps
module csel_seq_test;
  localparam int SETUP = 13;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [1:0]  req_op;
  logic [1:0]  req_tgt;
  logic [15:0] req_data;
  logic        miso;
  logic        busy, done, err, sclk, mosi;
  logic [15:0] rsp_data, cfg_q;
  logic [2:0]  cs_n;

  csel_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_tgt(req_tgt), .req_data(req_data), .miso(miso), .busy(busy),
    .done(done), .err(err), .rsp_data(rsp_data), .cs_n(cs_n),
    .cfg_q(cfg_q), .sclk(sclk), .mosi(mosi)
  );

  always #4 clk = ~clk; // 125 MHz

  int total = 0;
  int fails = 0;
  int cyc = 0;

  // serial target model
  logic [15:0] sl_resp = '0;
  int          sl_idx = -1;
  logic [15:0] mosi_cap = '0;
  int          sclk_rises = 0;
  assign miso = (sl_idx >= 0 && sl_idx < 16) ? sl_resp[sl_idx] : 1'b0;
  always @(negedge sclk) sl_idx = sl_idx - 1;
  always @(posedge sclk) begin
    mosi_cap = {mosi_cap[14:0], mosi};
    sclk_rises = sclk_rises + 1;
  end

  // monitors
  int done_cnt = 0, multi_low = 0, cfg_bad = 0, done_bad = 0;
  int cs0_cyc = 0, rise_gap = 0;
  bit rise_seen = 0;
  logic sclk_prev = 1'b0;
  logic [15:0] cfg_prev = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (done) done_cnt++;
      if (done && cs_n !== 3'b111) done_bad++;
      if ($countones(~cs_n) > 1) multi_low++;
      if (cfg_q !== cfg_prev && cfg_prev !== 16'h0 && cfg_q !== 16'h0) cfg_bad++;
      cfg_prev = cfg_q;
      if (cs_n[0] === 1'b0) cs0_cyc++;
      else begin cs0_cyc = 0; rise_seen = 0; end
      if (sclk && !sclk_prev && cs0_cyc > 0 && !rise_seen) begin
        rise_gap = cs0_cyc;
        rise_seen = 1;
      end
      sclk_prev = sclk;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int nbits(input int t);
    return (t == 1) ? 8 : 12;
  endfunction
  function automatic logic [15:0] ecfg(input int t);
    return (t == 0) ? 16'h06AB : (t == 1) ? 16'h0387 : 16'h01AB;
  endfunction
  function automatic logic [15:0] mask(input int t);
    return 16'((32'h1 << nbits(t)) - 1);
  endfunction
  function automatic logic [2:0] ecs(input int t);
    return ~(3'b001 << t);
  endfunction

  task automatic send(input logic [1:0] op, input logic [1:0] t, input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_tgt = t; req_data = d;
    @(posedge clk);
    #1;
    req_valid = 1'b0; req_op = 2'b00;
  endtask

  task automatic prep(input int t, input logic [15:0] r);
    sl_resp = r; sl_idx = nbits(t) - 1; mosi_cap = '0; sclk_rises = 0;
  endtask

  task automatic wait_busy(output bit ok);
    ok = 0;
    for (int i = 0; i < 2000 && !ok; i++) begin
      @(negedge clk);
      if (busy) ok = 1;
    end
  endtask

  task automatic wait_done(output logic [15:0] r, output logic e, output bit ok);
    ok = 0; r = '0; e = 1'b0;
    for (int i = 0; i < 3000 && !ok; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; r = rsp_data; e = err; end
    end
  endtask

  task automatic run_pair(input int t, input logic [15:0] d, input logic [15:0] r);
    bit ok; logic [15:0] got; logic e;
    prep(t, r);
    send(2'b01, 2'(t), d);
    wait_busy(ok);
    chk(ok, "R5 busy after start", 32'(busy), 1);
    chk(cs_n == ecs(t), "R2 single select", 32'(cs_n), 32'(ecs(t)));
    chk(cfg_q == ecfg(t), "R3 cfg loaded", 32'(cfg_q), 32'(ecfg(t)));
    if (t != 0) chk(sclk_rises == 0, "R5 no word for non-touch start", sclk_rises, 0);
    send(2'b10, 2'($urandom % 4), 16'h0);
    wait_done(got, e, ok);
    chk(ok, "R6 stop done", 32'(ok), 1);
    chk(got == ((t == 0) ? (r & mask(t)) : 16'h0), "R6 stop data", got,
        (t == 0) ? (r & mask(t)) : 0);
    chk(cs_n == 3'b111 && !busy, "R7 release at stop", {busy, cs_n}, 32'h7);
    if (t == 0) begin
      chk(sclk_rises == 12, "R4 frame length", sclk_rises, 12);
      chk(mosi_cap[11:0] == d[11:0], "R4 mosi word", mosi_cap[11:0], d[11:0]);
      chk(rise_gap > SETUP, "R5 setup wait", rise_gap, SETUP + 1);
    end
  endtask

  task automatic run_xchg(input int t, input logic [15:0] d, input logic [15:0] r);
    bit ok; logic [15:0] got; logic e;
    prep(t, r);
    send(2'b11, 2'(t), d);
    wait_done(got, e, ok);
    chk(ok, "R8 exchange done", 32'(ok), 1);
    chk(got == ((t == 2) ? 16'h0 : (r & mask(t))), "R8 exchange data", got,
        (t == 2) ? 0 : (r & mask(t)));
    chk(sclk_rises == nbits(t), "R4 exchange frame length", sclk_rises, nbits(t));
    chk((mosi_cap & mask(t)) == (d & mask(t)), "R4 exchange mosi", mosi_cap & mask(t), d & mask(t));
    chk(cfg_q == ecfg(t), "R3 exchange cfg", cfg_q, ecfg(t));
    chk(!busy && cs_n == 3'b111 && !e, "R8 exchange leaves idle", {e, busy, cs_n}, 32'h7);
  endtask

  task automatic run_bad(input logic [1:0] op);
    bit ok; logic [15:0] got; logic e;
    send(op, 2'd3, 16'hFFFF);
    wait_done(got, e, ok);
    chk(ok && e, "R9 error pulse", {ok, e}, 32'h3);
    chk(got == 16'h0 && cs_n == 3'b111 && !busy, "R9 no select, zero data", {got, cs_n}, 32'h7);
    @(negedge clk);
    chk(!err, "R9 error is one cycle", 32'(err), 0);
  endtask

  initial begin : watchdog
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    total++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 150000);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : main
    bit ok; logic [15:0] got; logic e; int dc;
    req_valid = 0; req_op = 0; req_tgt = 0; req_data = 0;
    rst_n = 1'b0;
    void'($urandom(32'h5EED_0042));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(cs_n == 3'b111, "R1 selects high", cs_n, 7);
    chk(!busy && !done && !err, "R1 flags low", {busy, done, err}, 0);
    chk(!sclk && !mosi && cfg_q == 0 && rsp_data == 0, "R1 serial and data idle",
        {sclk, mosi, cfg_q}, 0);

    // R6 stop while idle
    send(2'b10, 2'd1, 16'h0);
    wait_done(got, e, ok);
    chk(ok && got == 0 && !e, "R6 idle stop returns zero", got, 0);

    // directed sessions on every target
    run_pair(0, 16'h0ABC, 16'h05A3);
    run_pair(1, 16'h1234, 16'h00C7);
    run_pair(2, 16'h0055, 16'h0FFF);

    // R10 start and exchange during an open session are ignored
    prep(1, 16'h0);
    send(2'b01, 2'd1, 16'h0);
    wait_busy(ok);
    dc = done_cnt;
    send(2'b01, 2'd0, 16'h0123);
    send(2'b11, 2'd2, 16'h0456);
    send(2'b01, 2'd3, 16'h0);
    repeat (40) @(negedge clk);
    chk(done_cnt == dc, "R10 no completion for ignored requests", done_cnt, dc);
    chk(busy && cs_n == 3'b101, "R10 session unchanged", {busy, cs_n}, 32'hD);
    chk(cfg_q == 16'h0387 && sclk_rises == 0, "R10 cfg and engine untouched", cfg_q, 16'h0387);
    send(2'b10, 2'd0, 16'h0);
    wait_done(got, e, ok);
    chk(ok && got == 0, "R6 monitor stop returns zero", got, 0);

    // directed exchanges
    run_xchg(0, 16'h0F0F, 16'h0A5A);
    run_xchg(1, 16'h00A5, 16'h003C);
    run_xchg(2, 16'h0FFF, 16'h0123);

    // invalid target
    run_bad(2'b01);
    run_bad(2'b11);

    // R10 overlap: stop arrives while exchange is still shifting
    prep(0, 16'h0321);
    dc = done_cnt;
    send(2'b11, 2'd0, 16'h0777);
    repeat (3) @(negedge clk);
    send(2'b10, 2'd0, 16'h0);
    wait_done(got, e, ok);
    chk(got == 16'h0321, "R10 overlap keeps exchange data", got, 16'h0321);
    repeat (10) @(negedge clk);
    chk(done_cnt == dc + 1 && !busy, "R10 one completion for overlap", done_cnt, dc + 1);

    // random mix
    for (int i = 0; i < 40; i++) begin
      int t; int k; logic [15:0] d; logic [15:0] r;
      t = int'($urandom % 4);
      k = int'($urandom % 2);
      d = 16'($urandom);
      r = 16'($urandom);
      if (t == 3) run_bad(k ? 2'b11 : 2'b01);
      else if (k == 1) run_xchg(t, d, r);
      else run_pair(t, d, r);
    end

    chk(multi_low == 0, "R2 never two selects low", multi_low, 0);
    chk(cfg_bad == 0, "R3 cfg cleared before each load", cfg_bad, 0);
    chk(done_bad == 0, "R7 done only with all released", done_bad, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule